// File: doc/BRIEF.md
# Snapshot-Readback Interval Timer

This block is a 32-bit down-counting interval timer, programmed and read through a byte-wide register window. A control register lets software do four things: start and stop the count, allow a timeout interrupt, pick one of several prescaled count rates, and choose what a read of the value register returns. A read can return either the live count or the reload value. The value register is four bytes wide. A write to it fills the reload value. A read of it goes through a snapshot latch, so a 32-bit number can be read one byte at a time without tearing.

When the count reaches zero, the next count tick reloads the counter from the reload register and sets a sticky timeout flag. Software clears the flag by writing one to it. Software can poll the flag in the control register. If the interrupt is allowed, the flag also drives the interrupt line and the pending bit in the status register. The counter picks up a new reload value only when it is next started or next reloads on its own.

Top module: `ivt_timer`

## Requirements
- R1: After reset every register is zero: control, reload value, count, flag and read data. The interrupt output is low.
- R2: The control byte at address 0 holds these fields: bit 0 run, bit 1 interrupt allow, bit 2 read source (1 = reload value), bits 4:3 rate select, bit 7 timeout flag. With rate select s, one count tick occurs every BASE_DIV·2^s clock cycles. With reload value L, the first timeout edge comes (L+1)·BASE_DIV·2^s clock edges after the edge that sets run.
- R3: The count goes down by one on each tick. It holds its value while run is 0.
- R4: A tick at a count of zero reloads the counter from the reload register and sets the flag. Every later period therefore also lasts (L+1)·BASE_DIV·2^s cycles.
- R5: A write that changes run from 0 to 1 loads the counter from the reload register. Writes to the reload bytes (addresses 4 to 7, where 4 is the least significant byte) leave a running count unchanged.
- R6: A control write with bit 7 set clears the flag. A control write with bit 7 at 0 leaves the flag as it is.
- R7: The interrupt output and status bit 0 (address 1) both equal flag AND interrupt allow. Control bit 7 shows the flag whatever the interrupt allow bit is.
- R8: A value-register read returns bytes of the live count when read source is 0, and bytes of the reload value when it is 1.
- R9: A read of byte 0 (address 4) captures the whole 32-bit source into a snapshot. Reads of bytes 1 to 3 then return the captured bytes, in any order, even if the count or the reload value changes meanwhile.
- R10: The snapshot is released once all four bytes have been read. After that, reads of bytes 1 to 3 return live source bytes. A new byte-0 read always replaces the snapshot.
- R11: Read data appears on the clock edge that samples the read strobe and holds until the next read. Addresses 2 and 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_addr | input | 3 | Register address (0 control, 1 status, 4..7 value bytes) |
| wr_stb | input | 1 | Write strobe, one cycle per byte |
| wr_data | input | 8 | Write data byte |
| rd_stb | input | 1 | Read strobe, one cycle per byte |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Timeout interrupt, flag AND interrupt allow |

## Verification
The bench builds the timer with BASE_DIV = 2, RATE_W = 2 and W = 32. This makes the shortest tick spacing two cycles and the longest sixteen. Every rate select can then be swept to two full timeouts in under a hundred cycles each, with the timeout edge checked to the exact cycle. The 32-bit width is kept, so a reload value of 2^24 puts a byte-3 carry within a few ticks. This shows the snapshot holding a value that the live count has already left.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    // Control byte field positions
    localparam int CB_RUN  = 0;
    localparam int CB_IE   = 1;
    localparam int CB_SRC  = 2;
    localparam int CB_RATE = 3;
    localparam int CB_TO   = 7;

    // Offsets inside the lower half of the register window
    localparam int OFS_CTRL = 0;
    localparam int OFS_STAT = 1;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/ivt_prescale.sv
module ivt_prescale #(
    parameter int BASE_DIV = 4,
    parameter int RATE_W   = 2,
    localparam int RATES   = 1 << RATE_W,
    localparam int PRE_W   = $clog2(BASE_DIV << (RATES - 1))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    logic [PRE_W-1:0] lim [RATES];

    genvar g;
    generate
        for (g = 0; g < RATES; g++) begin : g_lim
            assign lim[g] = PRE_W'((BASE_DIV << g) - 1);
        end
    endgenerate

    assign tick = run && (st_q.cnt >= lim[rate]);

    always_comb begin
        st_d = st_q;
        if (!run || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ivt_count.sv
module ivt_count #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         tick,
    input  logic         flag_clr,
    input  logic [W-1:0] load,
    output logic [W-1:0] count,
    output logic         flag
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         flag;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    expire;

    assign expire = !start && tick && (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.cnt = load;
        end else if (tick) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = load;
            end else begin
                st_d.cnt = st_q.cnt - W'(1);
            end
        end
        if (expire) begin
            st_d.flag = 1'b1;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
    assign flag  = st_q.flag;

endmodule

// File: rtl/ivt_snap.sv
module ivt_snap #(
    parameter int W = 32,
    localparam int NB    = W / 8,
    localparam int IDX_W = $clog2(NB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_val,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     src,
    output logic [7:0]       byte_out
);

    typedef struct packed {
        logic [W-1:0]  val;
        logic          held;
        logic [NB-1:0] seen;
    } snap_st_t;

    snap_st_t     st_d, st_q;
    logic [W-1:0] sel;

    always_comb begin
        st_d = st_q;
        sel  = st_q.held ? st_q.val : src;
        if (rd_val) begin
            if (idx == '0) begin
                st_d.val  = src;
                st_d.held = 1'b1;
                st_d.seen = NB'(1);
                sel       = src;
            end else if (st_q.held) begin
                st_d.seen = st_q.seen | (NB'(1) << idx);
                if (&st_d.seen) begin
                    st_d.held = 1'b0;
                    st_d.seen = '0;
                end
            end
        end
    end

    always_comb begin
        byte_out = '0;
        for (int b = 0; b < NB; b++) begin
            if (idx == IDX_W'(b)) begin
                byte_out = sel[b*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer #(
    parameter int W        = 32,
    parameter int BASE_DIV = 4,
    parameter int RATE_W   = 2,
    localparam int NB      = W / 8,
    localparam int IDX_W   = $clog2(NB),
    localparam int ADDR_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              wr_stb,
    input  logic [7:0]        wr_data,
    input  logic              rd_stb,
    output logic [7:0]        rd_data,
    output logic              irq
);
    import ivt_pkg::*;

    typedef struct packed {
        logic              run;
        logic              ie;
        logic              src_load;
        logic [RATE_W-1:0] rate;
        logic [W-1:0]      load;
        logic [7:0]        rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    logic             is_val;
    logic [IDX_W-1:0] idx;
    logic             hit_ctrl;
    logic             hit_stat;
    logic             run_w;
    logic             start_w;
    logic             clr_w;
    logic             tick_w;
    logic             flag_w;
    logic [W-1:0]     count_w;
    logic [W-1:0]     load_w;
    logic [W-1:0]     src_w;
    logic [7:0]       snap_byte;
    logic [7:0]       ctrl_byte;
    logic [7:0]       stat_byte;

    assign is_val   = acc_addr[ADDR_W-1];
    assign idx      = acc_addr[IDX_W-1:0];
    assign hit_ctrl = !is_val && (idx == IDX_W'(OFS_CTRL));
    assign hit_stat = !is_val && (idx == IDX_W'(OFS_STAT));

    assign run_w   = st_q.run;
    assign load_w  = st_q.load;
    assign start_w = wr_stb && hit_ctrl && wr_data[CB_RUN] && !st_q.run;
    assign clr_w   = wr_stb && hit_ctrl && wr_data[CB_TO];
    assign src_w   = st_q.src_load ? st_q.load : count_w;

    ivt_prescale #(
        .BASE_DIV (BASE_DIV),
        .RATE_W   (RATE_W)
    ) pre_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_w),
        .rate  (st_q.rate),
        .tick  (tick_w)
    );

    ivt_count #(
        .W (W)
    ) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_w),
        .tick     (tick_w),
        .flag_clr (clr_w),
        .load     (st_q.load),
        .count    (count_w),
        .flag     (flag_w)
    );

    ivt_snap #(
        .W (W)
    ) snap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_val   (rd_stb && is_val),
        .idx      (idx),
        .src      (src_w),
        .byte_out (snap_byte)
    );

    always_comb begin
        ctrl_byte                    = '0;
        ctrl_byte[CB_RUN]            = st_q.run;
        ctrl_byte[CB_IE]             = st_q.ie;
        ctrl_byte[CB_SRC]            = st_q.src_load;
        ctrl_byte[CB_RATE +: RATE_W] = st_q.rate;
        ctrl_byte[CB_TO]             = flag_w;
        stat_byte                    = '0;
        stat_byte[0]                 = flag_w && st_q.ie;
    end

    always_comb begin
        st_d = st_q;
        if (wr_stb) begin
            if (hit_ctrl) begin
                st_d.run      = wr_data[CB_RUN];
                st_d.ie       = wr_data[CB_IE];
                st_d.src_load = wr_data[CB_SRC];
                st_d.rate     = wr_data[CB_RATE +: RATE_W];
            end else if (is_val) begin
                for (int b = 0; b < NB; b++) begin
                    if (idx == IDX_W'(b)) begin
                        st_d.load[b*8 +: 8] = wr_data;
                    end
                end
            end
        end
        if (rd_stb) begin
            if (is_val) begin
                st_d.rdata = snap_byte;
            end else if (hit_ctrl) begin
                st_d.rdata = ctrl_byte;
            end else if (hit_stat) begin
                st_d.rdata = stat_byte;
            end else begin
                st_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rdata;
    assign irq     = flag_w && st_q.ie;

endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic         start,
    input logic         tick,
    input logic [W-1:0] count,
    input logic [W-1:0] load,
    input logic         flag,
    input logic         irq
);

    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> $stable(count));

    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !start) |=> $stable(count));

    p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !start && count != '0) |=> (count == $past(count) - W'(1)));

    p_flag_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(tick) && $past(count) == '0));

    p_start_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (count == $past(load)));

    p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

endmodule

bind ivt_timer ivt_timer_chk #(.W(W)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_w),
    .start (start_w),
    .tick  (tick_w),
    .count (count_w),
    .load  (load_w),
    .flag  (flag_w),
    .irq   (irq)
);

// File: tb/ivt_timer_tb_top.sv
module ivt_timer_tb_top;

    localparam int BD = 2;
    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_STAT = 3'd1;
    localparam logic [2:0] A_V0   = 3'd4;
    localparam logic [7:0] F_RUN  = 8'h01;
    localparam logic [7:0] F_IE   = 8'h02;
    localparam logic [7:0] F_SRC  = 8'h04;
    localparam logic [7:0] F_CLR  = 8'h80;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] acc_addr;
    logic       wr_stb;
    logic [7:0] wr_data;
    logic       rd_stb;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ivt_timer #(.W(32), .BASE_DIV(BD), .RATE_W(2)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_addr (acc_addr),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .rd_stb   (rd_stb),
        .rd_data  (rd_data),
        .irq      (irq)
    );

    function automatic int f_period(int l, int s);
        return (l + 1) * (BD << s);
    endfunction

    function automatic logic [7:0] f_byte(logic [31:0] v, int i);
        return v[i*8 +: 8];
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        acc_addr = a; wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        acc_addr = a; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        d = rd_data;
    endtask

    task automatic set_load(logic [31:0] v);
        for (int i = 0; i < 4; i++) wr(A_V0 + 3'(i), f_byte(v, i));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  d, a0, b0;
        logic [31:0] v;
        int          n, l;
        int          ord [4];
        void'($urandom(32'h1f2e3d4c));
        rst_n = 1'b0; acc_addr = '0; wr_stb = 1'b0; wr_data = '0; rd_stb = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 irq", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(A_CTRL, d); chk("R1 ctrl", d, 0);
        rd(A_V0, d);   chk("R1 count", d, 0);

        // R2 R4 R6: every rate, two periods, flag clear behaviour
        for (int s = 0; s < 4; s++) begin
            l = 1 + int'($urandom % 5);
            n = f_period(l, s);
            set_load(32'(l));
            wr(A_CTRL, F_RUN | F_IE | 8'(s << 3));
            repeat (n - 1) @(negedge clk);
            chk("R2 before timeout", irq, 0);
            @(negedge clk);
            chk("R2 at timeout", irq, 1);
            wr(A_CTRL, F_RUN | F_IE | 8'(s << 3));
            chk("R6 zero leaves flag", irq, 1);
            wr(A_CTRL, F_RUN | F_IE | F_CLR | 8'(s << 3));
            chk("R6 clear", irq, 0);
            repeat (n - 3) @(negedge clk);
            chk("R4 before second", irq, 0);
            @(negedge clk);
            chk("R4 second timeout", irq, 1);
            wr(A_CTRL, F_CLR);
            chk("R6 clear stop", irq, 0);
        end

        // R7 polling without interrupt
        set_load(32'd2);
        wr(A_CTRL, F_RUN);
        repeat (10) @(negedge clk);
        chk("R7 irq masked", irq, 0);
        rd(A_CTRL, d); chk("R7 flag visible", d, 8'h81);
        rd(A_STAT, d); chk("R7 status masked", d, 0);
        wr(A_CTRL, F_RUN | F_IE);
        chk("R7 irq on allow", irq, 1);
        rd(A_STAT, d); chk("R7 status pending", d, 1);
        wr(A_CTRL, F_CLR);

        // R9 R10 R8 live snapshot across a byte-3 borrow
        set_load(32'h0100_0000);
        wr(A_CTRL, F_RUN);
        rd(A_V0, d);          chk("R9 byte0 capture", d, 8'h00);
        repeat (10) @(negedge clk);
        rd(A_V0 + 3'd3, d);   chk("R9 frozen byte3", d, 8'h01);
        rd(A_V0 + 3'd1, d);   chk("R9 frozen byte1", d, 8'h00);
        rd(A_V0 + 3'd2, d);   chk("R9 frozen byte2", d, 8'h00);
        rd(A_V0 + 3'd3, d);   chk("R10 released byte3", d, 8'h00);
        rd(A_V0 + 3'd1, d);   chk("R8 live byte1", d, 8'hFF);

        // R5 reload write does not disturb running count; restart loads
        set_load(32'h0A0B_0C0D);
        rd(A_V0 + 3'd3, d);   chk("R5 count kept byte3", d, 8'h00);
        rd(A_V0 + 3'd2, d);   chk("R5 count kept byte2", d, 8'hFF);
        wr(A_CTRL, 8'h00);
        wr(A_CTRL, F_RUN);
        rd(A_V0, d);          chk("R5 start byte0", d, 8'h0D);
        rd(A_V0 + 3'd3, d);   chk("R5 start byte3", d, 8'h0A);
        rd(A_V0 + 3'd1, d);   chk("R5 start byte1", d, 8'h0C);
        rd(A_V0 + 3'd2, d);   chk("R5 start byte2", d, 8'h0B);

        // R3 hold while stopped
        wr(A_CTRL, 8'h00);
        rd(A_V0, a0);
        repeat (20) @(negedge clk);
        rd(A_V0, b0);
        chk("R3 hold stopped", b0, a0);

        // R9 R10 reload-source snapshot replaced by new byte0 read
        set_load(32'h1122_3344);
        wr(A_CTRL, F_SRC);
        rd(A_V0, d);          chk("R8 load byte0", d, 8'h44);
        set_load(32'h5566_7788);
        rd(A_V0 + 3'd3, d);   chk("R9 load frozen", d, 8'h11);
        rd(A_V0, d);          chk("R10 new snap byte0", d, 8'h88);
        rd(A_V0 + 3'd3, d);   chk("R10 new snap byte3", d, 8'h55);
        rd(A_V0 + 3'd1, d);   chk("R10 new snap byte1", d, 8'h77);
        rd(A_V0 + 3'd2, d);   chk("R10 new snap byte2", d, 8'h66);

        // R8 R9 random reload values, random write and read orders
        for (int it = 0; it < 16; it++) begin
            v = $urandom;
            for (int i = 0; i < 4; i++) ord[i] = i;
            for (int i = 3; i > 0; i--) begin
                int j = int'($urandom % (i + 1));
                int t = ord[i]; ord[i] = ord[j]; ord[j] = t;
            end
            for (int i = 0; i < 4; i++) wr(A_V0 + 3'(ord[i]), f_byte(v, ord[i]));
            rd(A_V0, d); chk("R8 rand byte0", d, f_byte(v, 0));
            for (int i = 0; i < 4; i++) begin
                if (ord[i] != 0) begin
                    rd(A_V0 + 3'(ord[i]), d);
                    chk("R9 rand byte", d, f_byte(v, ord[i]));
                end
            end
        end

        // R11 unmapped addresses and held data
        rd(3'd2, d); chk("R11 addr2", d, 0);
        rd(3'd3, d); chk("R11 addr3", d, 0);
        wr(A_CTRL, F_SRC | F_IE);
        repeat (3) @(negedge clk);
        chk("R11 held", rd_data, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule